// File: doc/BRIEF.md
# C-Channel Control and Diagnostics Register File

This block sits behind the serial port deserializer of a two-wire line transceiver. Once per frame it receives the 8-bit control byte carried in the C channel, together with a one-cycle byte strobe. The two low bits of the byte choose where it goes: into a control register that holds the line configuration, or into a diagnostics register that holds the test features. Bytes with any other select code are dropped. A reserved pattern in the upper nibble does not load the register normally. Instead it forces one of two fixed default configurations, and the chosen one depends on bit 3.

Diagnostics are transient by design. At every frame pulse the diagnostics register clears itself, unless the control register's keep bit is set or a diagnostics byte arrives in the same cycle. The block also captures the link status inputs at each frame pulse into the outgoing status byte. Every decoded enable is driven straight from a flop.

Top module: `cdsr_regfile`

## Requirements
- R1: A byte is accepted only when `cbyte_valid` is high. Byte bits [1:0] = 00 write the control register. Bit 1 = 1 with bit 0 = 0 writes the diagnostics register. Outputs change on the clock edge that samples the strobe.
- R2: Control byte fields: bit 2 is the diagnostics keep bit; bit 3 drives `rate_160` (0 = 80 kbit/s, 1 = 160 kbit/s); bit 4 drives `d_in_b`; bit 5 drives `prescr_en`; bit 6 drives `fast_conv`; bit 7 drives `tx_hk`.
- R3: Diagnostics byte fields: `loop_sel` = {bit 2, bit 3}, where 00 = none, 01 = data input to data output, 10 = line out to line in, and 11 = data output to data input. Bit 4 drives `force_unsync`, bit 5 drives `poly_swap`, bit 6 drives `line_out_off`, and bit 7 is ignored.
- R4: At a frame pulse with no diagnostics write in that cycle, the diagnostics register clears if the keep bit is 0 and is unchanged if the keep bit is 1.
- R5: When a diagnostics write and a frame pulse fall in the same cycle, the written value is kept.
- R6: A control or diagnostics byte with bits [7:4] = 1111 selects a default configuration. `rate_160` takes bit 3. The keep bit, `d_in_b`, `prescr_en`, `fast_conv` and `tx_hk` become 0, and the diagnostics register clears.
- R7: At each frame pulse the status byte is loaded as: bit 0 = `sync_ok`, bits [2:1] = `quality[1:0]`, bit 3 = `rx_hk`, bits [6:4] = 111, bit 7 = 0. Between pulses it holds its value.
- R8: Synchronous reset sets every control and diagnostics output to 0 (the 80 kbit/s default) and sets `status_byte` to 8'h70.
- R9: A strobed byte with bit 0 = 1 changes neither register, including one whose upper nibble is 1111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_pulse | input | 1 | One-cycle frame start marker |
| cbyte_valid | input | 1 | Strobe for `cbyte` |
| cbyte | input | 8 | Received C-channel byte |
| sync_ok | input | 1 | Frame sync acquired |
| quality | input | 2 | Channel quality estimate |
| rx_hk | input | 1 | Received housekeeping bit |
| rate_160 | output | 1 | 160 kbit/s line rate selected |
| d_in_b | output | 1 | Whole D channel carried in the B1 slot |
| prescr_en | output | 1 | Prescrambler and deprescrambler enable |
| fast_conv | output | 1 | Fast echo canceller convergence |
| tx_hk | output | 1 | Housekeeping bit to transmit |
| loop_sel | output | 2 | Loopback select |
| force_unsync | output | 1 | Force loss of frame sync |
| poly_swap | output | 1 | Swap scrambling polynomials |
| line_out_off | output | 1 | Disable line output |
| status_byte | output | 8 | Outgoing status byte |

## Verification
A diagnostics write and a frame-pulse clear can land in the same cycle, and they target the same register. The stimulus table raises the byte strobe with a diagnostics byte and the frame pulse on one clock edge, while the keep bit is 0. On the next cycle the check expects the written loopback and polynomial fields, not zeros. The following frame pulse, which carries no write, is then expected to clear them.

// File: rtl/cdsr_pkg.sv
package cdsr_pkg;
  localparam int BYTE_W = 8;
  localparam int QUAL_W = 2;
  localparam int LOOP_W = 2;

  typedef enum logic [1:0] {
    WR_NONE    = 2'd0,
    WR_CTRL    = 2'd1,
    WR_DIAG    = 2'd2,
    WR_DEFAULT = 2'd3
  } wr_kind_e;

  typedef struct packed {
    logic tx_hk;
    logic fast_conv;
    logic prescr_en;
    logic d_in_b;
    logic rate_160;
    logic diag_keep;
  } ctrl_t;

  typedef struct packed {
    logic              line_out_off;
    logic              poly_swap;
    logic              force_unsync;
    logic [LOOP_W-1:0] loop_sel;
  } diag_t;
endpackage

// File: rtl/cdsr_decode.sv
module cdsr_decode
  import cdsr_pkg::*;
(
  input  logic              valid,
  input  logic [BYTE_W-1:0] cbyte,
  output wr_kind_e          kind
);
  localparam int NIB_LO = BYTE_W - 4;

  logic reserved_nib;
  assign reserved_nib = &cbyte[BYTE_W-1:NIB_LO];

  always_comb begin
    kind = WR_NONE;
    if (valid && !cbyte[0]) begin
      if (reserved_nib)  kind = WR_DEFAULT;
      else if (cbyte[1]) kind = WR_DIAG;
      else               kind = WR_CTRL;
    end
  end
endmodule

// File: rtl/cdsr_ctrl_reg.sv
module cdsr_ctrl_reg
  import cdsr_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  wr_kind_e kind,
  input  logic [7:2] fields,
  output ctrl_t    ctrl_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else begin
      unique case (kind)
        WR_CTRL: begin
          ctrl_q.diag_keep <= fields[2];
          ctrl_q.rate_160  <= fields[3];
          ctrl_q.d_in_b    <= fields[4];
          ctrl_q.prescr_en <= fields[5];
          ctrl_q.fast_conv <= fields[6];
          ctrl_q.tx_hk     <= fields[7];
        end
        WR_DEFAULT: begin
          ctrl_q          <= '0;
          ctrl_q.rate_160 <= fields[3];
        end
        default: ctrl_q <= ctrl_q;
      endcase
    end
  end
endmodule

// File: rtl/cdsr_diag_reg.sv
module cdsr_diag_reg
  import cdsr_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  wr_kind_e kind,
  input  logic [6:2] fields,
  input  logic     frame,
  input  logic     keep,
  output diag_t    diag_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      diag_q <= '0;
    end else if (kind == WR_DIAG) begin
      diag_q.loop_sel     <= {fields[2], fields[3]};
      diag_q.force_unsync <= fields[4];
      diag_q.poly_swap    <= fields[5];
      diag_q.line_out_off <= fields[6];
    end else if (kind == WR_DEFAULT) begin
      diag_q <= '0;
    end else if (frame && !keep) begin
      diag_q <= '0;
    end
  end
endmodule

// File: rtl/cdsr_status_reg.sv
module cdsr_status_reg
  import cdsr_pkg::*;
#(
  parameter logic REV_ID = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame,
  input  logic              sync_ok,
  input  logic [QUAL_W-1:0] quality,
  input  logic              rx_hk,
  output logic [BYTE_W-1:0] status_q
);
  localparam int FIXED_W = BYTE_W - QUAL_W - 3;
  localparam logic [FIXED_W-1:0] FIXED_ONES = '1;

  always_ff @(posedge clk) begin
    if (rst)        status_q <= {REV_ID, FIXED_ONES, 1'b0, {QUAL_W{1'b0}}, 1'b0};
    else if (frame) status_q <= {REV_ID, FIXED_ONES, rx_hk, quality, sync_ok};
  end
endmodule

// File: rtl/cdsr_regfile.sv
module cdsr_regfile
  import cdsr_pkg::*;
#(
  parameter logic REV_ID = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_pulse,
  input  logic              cbyte_valid,
  input  logic [BYTE_W-1:0] cbyte,
  input  logic              sync_ok,
  input  logic [QUAL_W-1:0] quality,
  input  logic              rx_hk,
  output logic              rate_160,
  output logic              d_in_b,
  output logic              prescr_en,
  output logic              fast_conv,
  output logic              tx_hk,
  output logic [LOOP_W-1:0] loop_sel,
  output logic              force_unsync,
  output logic              poly_swap,
  output logic              line_out_off,
  output logic [BYTE_W-1:0] status_byte
);
  wr_kind_e kind;
  ctrl_t    ctrl_q;
  diag_t    diag_q;
  logic     keep_w;

  cdsr_decode u_dec (
    .valid (cbyte_valid),
    .cbyte (cbyte),
    .kind  (kind)
  );

  cdsr_ctrl_reg u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .kind   (kind),
    .fields (cbyte[7:2]),
    .ctrl_q (ctrl_q)
  );

  assign keep_w = ctrl_q.diag_keep;

  cdsr_diag_reg u_diag (
    .clk    (clk),
    .rst    (rst),
    .kind   (kind),
    .fields (cbyte[6:2]),
    .frame  (frame_pulse),
    .keep   (keep_w),
    .diag_q (diag_q)
  );

  cdsr_status_reg #(.REV_ID(REV_ID)) u_stat (
    .clk      (clk),
    .rst      (rst),
    .frame    (frame_pulse),
    .sync_ok  (sync_ok),
    .quality  (quality),
    .rx_hk    (rx_hk),
    .status_q (status_byte)
  );

  assign rate_160     = ctrl_q.rate_160;
  assign d_in_b       = ctrl_q.d_in_b;
  assign prescr_en    = ctrl_q.prescr_en;
  assign fast_conv    = ctrl_q.fast_conv;
  assign tx_hk        = ctrl_q.tx_hk;
  assign loop_sel     = diag_q.loop_sel;
  assign force_unsync = diag_q.force_unsync;
  assign poly_swap    = diag_q.poly_swap;
  assign line_out_off = diag_q.line_out_off;
endmodule

// File: rtl/cdsr_regfile_chk.sv
module cdsr_regfile_chk (
  input logic       clk,
  input logic       rst,
  input logic       frame_pulse,
  input logic       cbyte_valid,
  input logic [7:0] cbyte,
  input logic       sync_ok,
  input logic [1:0] quality,
  input logic       rx_hk,
  input logic       rate_160,
  input logic       d_in_b,
  input logic       prescr_en,
  input logic       fast_conv,
  input logic       tx_hk,
  input logic [1:0] loop_sel,
  input logic       force_unsync,
  input logic       poly_swap,
  input logic       line_out_off,
  input logic [7:0] status_byte,
  input logic       diag_keep
);
  // R2: plain control write maps fields
  a_r2_ctrl_fields: assert property (@(posedge clk) disable iff (rst)
    (cbyte_valid && cbyte[1:0] == 2'b00 && cbyte[7:4] != 4'hF) |=>
      (tx_hk == $past(cbyte[7]) && fast_conv == $past(cbyte[6]) &&
       prescr_en == $past(cbyte[5]) && d_in_b == $past(cbyte[4]) &&
       rate_160 == $past(cbyte[3])));

  // R3 and R5: diagnostics write wins even with a frame pulse
  a_r5_write_beats_clear: assert property (@(posedge clk) disable iff (rst)
    (cbyte_valid && cbyte[1:0] == 2'b10 && cbyte[7:4] != 4'hF) |=>
      (loop_sel == {$past(cbyte[2]), $past(cbyte[3])} &&
       force_unsync == $past(cbyte[4]) && poly_swap == $past(cbyte[5]) &&
       line_out_off == $past(cbyte[6])));

  // R4: frame pulse clears diagnostics when keep bit is 0
  a_r4_frame_clear: assert property (@(posedge clk) disable iff (rst)
    (frame_pulse && !diag_keep && !(cbyte_valid && !cbyte[0])) |=>
      (loop_sel == 2'b00 && !force_unsync && !poly_swap && !line_out_off));

  // R6: default pattern
  a_r6_default: assert property (@(posedge clk) disable iff (rst)
    (cbyte_valid && !cbyte[0] && cbyte[7:4] == 4'hF) |=>
      (rate_160 == $past(cbyte[3]) && !tx_hk && !fast_conv && !prescr_en &&
       !d_in_b && !diag_keep && loop_sel == 2'b00 && !force_unsync &&
       !poly_swap && !line_out_off));

  // R9: odd select codes leave both registers unchanged
  a_r9_ignored: assert property (@(posedge clk) disable iff (rst)
    (cbyte_valid && cbyte[0] && !frame_pulse) |=>
      $stable({rate_160, d_in_b, prescr_en, fast_conv, tx_hk, loop_sel,
               force_unsync, poly_swap, line_out_off}));

  // R7: status capture and hold
  a_r7_status_load: assert property (@(posedge clk) disable iff (rst)
    frame_pulse |=> (status_byte[7:4] == 4'b0111 &&
                     status_byte[3] == $past(rx_hk) &&
                     status_byte[2:1] == $past(quality) &&
                     status_byte[0] == $past(sync_ok)));

  a_r7_status_hold: assert property (@(posedge clk) disable iff (rst)
    !frame_pulse |=> $stable(status_byte));

  // R8: reset values
  a_r8_reset: assert property (@(posedge clk)
    rst |=> (status_byte == 8'h70 && !rate_160 && !tx_hk && loop_sel == 2'b00 &&
             !diag_keep));
endmodule

bind cdsr_regfile cdsr_regfile_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .frame_pulse  (frame_pulse),
  .cbyte_valid  (cbyte_valid),
  .cbyte        (cbyte),
  .sync_ok      (sync_ok),
  .quality      (quality),
  .rx_hk        (rx_hk),
  .rate_160     (rate_160),
  .d_in_b       (d_in_b),
  .prescr_en    (prescr_en),
  .fast_conv    (fast_conv),
  .tx_hk        (tx_hk),
  .loop_sel     (loop_sel),
  .force_unsync (force_unsync),
  .poly_swap    (poly_swap),
  .line_out_off (line_out_off),
  .status_byte  (status_byte),
  .diag_keep    (keep_w)
);

// File: tb/cdsr_regfile_test.sv
module cdsr_regfile_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frame_pulse = 1'b0;
  logic       cbyte_valid = 1'b0;
  logic [7:0] cbyte = 8'h00;
  logic       sync_ok = 1'b0;
  logic [1:0] quality = 2'b00;
  logic       rx_hk = 1'b0;
  logic       rate_160, d_in_b, prescr_en, fast_conv, tx_hk;
  logic [1:0] loop_sel;
  logic       force_unsync, poly_swap, line_out_off;
  logic [7:0] status_byte;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cdsr_regfile uut (
    .clk(clk), .rst(rst), .frame_pulse(frame_pulse), .cbyte_valid(cbyte_valid),
    .cbyte(cbyte), .sync_ok(sync_ok), .quality(quality), .rx_hk(rx_hk),
    .rate_160(rate_160), .d_in_b(d_in_b), .prescr_en(prescr_en),
    .fast_conv(fast_conv), .tx_hk(tx_hk), .loop_sel(loop_sel),
    .force_unsync(force_unsync), .poly_swap(poly_swap),
    .line_out_off(line_out_off), .status_byte(status_byte)
  );

  // observed: {tx_hk, fast, prescr, d_in_b, rate, loop_sel[1:0], unsync, swap, lineoff}
  function automatic logic [9:0] obs();
    return {tx_hk, fast_conv, prescr_en, d_in_b, rate_160, loop_sel,
            force_unsync, poly_swap, line_out_off};
  endfunction

  // entry: {frame, valid, byte[7:0], expected[9:0]}
  localparam int NVEC = 14;
  localparam logic [19:0] VEC [NVEC] = '{
    {1'b0, 1'b1, 8'hAC, 10'b1_0_1_0_1_00_0_0_0}, // R2 control fields, keep=1
    {1'b0, 1'b1, 8'hD6, 10'b1_0_1_0_1_10_1_0_1}, // R3 diag, loop line
    {1'b1, 1'b0, 8'h00, 10'b1_0_1_0_1_10_1_0_1}, // R4 keep=1 holds
    {1'b0, 1'b1, 8'h08, 10'b0_0_0_0_1_10_1_0_1}, // R1 control, keep=0
    {1'b1, 1'b0, 8'h00, 10'b0_0_0_0_1_00_0_0_0}, // R4 frame clears
    {1'b1, 1'b1, 8'h2A, 10'b0_0_0_0_1_01_0_1_0}, // R5 write with frame
    {1'b1, 1'b0, 8'h00, 10'b0_0_0_0_1_00_0_0_0}, // R4 next frame clears
    {1'b0, 1'b1, 8'hFF, 10'b0_0_0_0_1_00_0_0_0}, // R9 ignored despite 1111
    {1'b0, 1'b1, 8'hB3, 10'b0_0_0_0_1_00_0_0_0}, // R9 ignored
    {1'b0, 1'b1, 8'h7A, 10'b0_0_0_0_1_01_1_1_1}, // R3 all diag bits
    {1'b0, 1'b1, 8'hF8, 10'b0_0_0_0_1_00_0_0_0}, // R6 default 160
    {1'b0, 1'b1, 8'hF2, 10'b0_0_0_0_0_00_0_0_0}, // R6 default 80 via diag path
    {1'b0, 1'b1, 8'hE4, 10'b1_1_1_0_0_00_0_0_0}, // R2 upper fields
    {1'b0, 1'b1, 8'h10, 10'b0_0_0_1_0_00_0_0_0}  // R2 d_in_b
  };

  task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic f, input logic v, input logic [7:0] b);
    @(negedge clk);
    frame_pulse = f;
    cbyte_valid = v;
    cbyte = b;
    @(negedge clk);
    frame_pulse = 1'b0;
    cbyte_valid = 1'b0;
    cbyte = 8'h00;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R8 reset outputs", obs(), 10'b0);
    check8("R8 reset status", status_byte, 8'h70);

    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][19], VEC[i][18], VEC[i][17:10]);
      check($sformatf("vector %0d", i), obs(), VEC[i][9:0]);
    end

    // R7 status capture
    sync_ok = 1'b1; quality = 2'b10; rx_hk = 1'b1;
    step(1'b1, 1'b0, 8'h00);
    check8("R7 status load", status_byte, 8'h7D);
    sync_ok = 1'b0; quality = 2'b01; rx_hk = 1'b0;
    step(1'b0, 1'b0, 8'h00);
    check8("R7 status hold", status_byte, 8'h7D);
    step(1'b1, 1'b0, 8'h00);
    check8("R7 status reload", status_byte, 8'h72);

    // R8 mid-run reset
    step(1'b0, 1'b1, 8'hAC);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R8 reset after writes", obs(), 10'b0);
    check8("R8 status after reset", status_byte, 8'h70);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule